// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block generates all the maintenance traffic an asynchronous DRAM needs, so the read/write access controller never has to deal with it. After reset it keeps the strobes idle for a programmable power-up pause. It then runs a fixed number of initialization cycles, and every one of these is a refresh cycle. When initialization is finished it raises `init_done`, and host access may start from that point on.

During normal operation an interval timer adds one refresh to a pending count once per refresh interval. The interval is sized so that every row is visited within the retention period. The sequencer asks for the strobes with `ref_req`. While the access controller holds `ref_gnt` high, it runs the pending cycles itself and flags with `strobe_own` that it is driving the strobe pins.

Two refresh styles are supported, chosen per cycle by `ras_only_mode`:

- **CAS-before-RAS:** the DRAM supplies the row internally, and the address pins are left undriven.
- **RAS-only:** the sequencer drives a row from an internal counter.

Successive CAS-before-RAS cycles keep CAS low and pulse only RAS. If an interval expires while an earlier refresh is still waiting, a sticky overdue flag is raised.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst` is high, all outputs hold their idle values: `ras_n`, `cas_n` and `we_n` are 1; `addr_oe`, `addr`, `init_done`, `ref_req`, `ref_overdue` and `strobe_own` are 0.
- R2: For the first PAUSE_CYC cycles after reset is released, `ras_n` and `cas_n` stay high.
- R3: After the pause, exactly INIT_CYCLES refresh cycles run without any grant. Each uses the style selected by `ras_only_mode`. `init_done` then rises and stays high. `ref_req` is low until then.
- R4: In a CAS-before-RAS cycle, `cas_n` has been low for at least T_CSR cycles when `ras_n` falls and stays low while `ras_n` is low. `we_n` is 1 and `addr_oe` is 0.
- R5: When another CAS-before-RAS refresh is due at the end of a RAS pulse, `cas_n` stays low through the precharge and only `ras_n` is pulsed again. In every case `ras_n` is high for at least T_RP cycles between pulses.
- R6: In a RAS-only cycle, `cas_n` stays high and `addr_oe` is 1 while `ras_n` is low. `addr` carries the row counter.
- R7: The row counter starts at 0 after reset and advances by one after each RAS-only cycle, wrapping from 1023 to 0. CAS-before-RAS cycles leave it unchanged.
- R8: After `init_done`, one refresh becomes pending every REFI_CYC cycles. With `ref_gnt` held high, the falling edges of `ras_n` are exactly REFI_CYC cycles apart.
- R9: After initialization, no refresh cycle starts unless `ref_gnt` is high. `ref_req` is high whenever a refresh is pending or the strobes are owned.
- R10: The pending count saturates at MAX_PEND. After a long denial, a grant yields exactly MAX_PEND cycles, and `ref_req` then falls.
- R11: `ref_overdue` is set when an interval expires while a refresh is still pending. It stays set until reset.
- R12: Each `ras_n` low pulse lasts exactly T_RAS cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only_mode | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS; sampled at the start of each cycle |
| ref_gnt | input | 1 | Access controller releases the strobes to the sequencer |
| ref_req | output | 1 | Sequencer needs the strobes |
| strobe_own | output | 1 | Sequencer is driving the strobe pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Refresh row address (RAS-only cycles) |
| addr_oe | output | 1 | Address output valid |
| init_done | output | 1 | Power-up sequence complete |
| ref_overdue | output | 1 | Sticky missed-interval flag |

## Verification
Every strobe result has a fixed latency, and each check is made at that cycle:

- **First strobe activity:** no sooner than PAUSE_CYC+1+T_CSR cycles after reset.
- **Granted refresh:** `ras_n` falls T_CSR+1 cycles after the grant is seen in idle.
- **Chained pulses:** they repeat every T_RAS+T_RP cycles.
- **Row address:** it is the value present while `ras_n` is low.
- **Overdue flag:** it is set one interval after a refresh is left unserved.

A driver queues the expected cycle descriptors: style, chained or not, and row. A monitor samples on the falling clock edge and pops one descriptor on each `ras_n` fall. It measures the pulse and precharge widths in sampled cycles. A `ras_n` fall with nothing queued is a failure.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_PRECH
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic addr_oe;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, addr_oe: 1'b0};

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Strobe pattern for a phase; cas_hold keeps CAS low across a precharge
    function automatic strobe_t drive_strobes(input seq_state_e st, input logic ronly,
                                              input logic cas_hold);
        strobe_t s;
        logic    live;
        s     = STROBE_REST;
        live  = (st == ST_SETUP) || (st == ST_ACTIVE);
        s.ras_n   = (st != ST_ACTIVE);
        s.cas_n   = ~(~ronly & (live | ((st == ST_PRECH) & cas_hold)));
        s.addr_oe = ronly & live;
        return s;
    endfunction

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int unsigned REFI_CYC = 740,
    parameter int unsigned MAX_PEND = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic served,
    output logic pend_any,
    output logic pend_multi,
    output logic overdue
);
    localparam int unsigned TW = $clog2(REFI_CYC + 1);
    localparam int unsigned PW = $clog2(MAX_PEND + 1);

    logic [TW-1:0] tcnt;
    logic [PW-1:0] pend;
    logic          tick;

    assign tick = run && (tcnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= TW'(REFI_CYC - 1);
        end else if (run) begin
            if (tcnt == '0) tcnt <= TW'(REFI_CYC - 1);
            else            tcnt <= tcnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            unique case ({tick, served})
                2'b10:   if (pend != PW'(MAX_PEND)) pend <= pend + 1'b1;
                2'b01:   if (pend != '0)            pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                  overdue <= 1'b0;
        else if (tick && (pend != '0) && !served) overdue <= 1'b1;
    end

    assign pend_any   = (pend != '0);
    assign pend_multi = (pend > PW'(1));

endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
    parameter int unsigned ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)                        row <= '0;
        else if (adv && row == ROW_LAST) row <= '0;
        else if (adv)                    row <= row + 1'b1;
    end

endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC   = 10100,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned T_CSR       = 1,
    parameter int unsigned T_RAS       = 7,
    parameter int unsigned T_RP        = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    mode_ronly,
    input  logic    gnt,
    input  logic    pend_any,
    input  logic    pend_multi,
    output strobe_t strb,
    output logic    own,
    output logic    init_done,
    output logic    served,
    output logic    row_adv
);
    localparam int unsigned DMAX = max_of4(PAUSE_CYC, T_CSR, T_RAS, T_RP);
    localparam int unsigned DW   = $clog2(DMAX + 1);
    localparam int unsigned IW   = $clog2(INIT_CYCLES + 1);

    seq_state_e    state;
    logic [DW-1:0] dcnt;
    logic [IW-1:0] init_left;
    logic          ronly_q;
    logic          chain_q;
    logic          dur_end;
    logic          start_now;
    logic          more_due;

    assign dur_end   = (dcnt == '0);
    assign start_now = (init_left != '0) || (init_done && pend_any && gnt);
    assign more_due  = init_done ? (pend_multi && gnt) : (init_left > IW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PAUSE;
            dcnt      <= DW'(PAUSE_CYC - 1);
            init_left <= IW'(INIT_CYCLES);
            init_done <= 1'b0;
            ronly_q   <= 1'b0;
            chain_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_PAUSE: begin
                    if (dur_end) state <= ST_IDLE;
                    else         dcnt  <= dcnt - 1'b1;
                end
                ST_IDLE: begin
                    if (start_now) begin
                        state   <= ST_SETUP;
                        dcnt    <= DW'(T_CSR - 1);
                        ronly_q <= mode_ronly;
                        chain_q <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (dur_end) begin
                        state <= ST_ACTIVE;
                        dcnt  <= DW'(T_RAS - 1);
                    end else begin
                        dcnt <= dcnt - 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    if (dur_end) begin
                        state   <= ST_PRECH;
                        dcnt    <= DW'(T_RP - 1);
                        chain_q <= !ronly_q && more_due;
                        if (!init_done) init_left <= init_left - 1'b1;
                    end else begin
                        dcnt <= dcnt - 1'b1;
                    end
                end
                ST_PRECH: begin
                    if (dur_end) begin
                        if (chain_q) begin
                            state <= ST_ACTIVE;
                            dcnt  <= DW'(T_RAS - 1);
                        end else begin
                            state <= ST_IDLE;
                            if (init_left == '0) init_done <= 1'b1;
                        end
                    end else begin
                        dcnt <= dcnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign strb    = drive_strobes(state, ronly_q, chain_q);
    assign own     = (state == ST_SETUP) || (state == ST_ACTIVE) || (state == ST_PRECH);
    assign served  = (state == ST_ACTIVE) && dur_end && init_done;
    assign row_adv = (state == ST_ACTIVE) && dur_end && ronly_q;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned ROW_W       = 10,
    parameter int unsigned PAUSE_CYC   = 10100,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned REFI_CYC    = 740,
    parameter int unsigned MAX_PEND    = 4,
    parameter int unsigned T_CSR       = 1,
    parameter int unsigned T_RAS       = 7,
    parameter int unsigned T_RP        = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_only_mode,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             strobe_own,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] addr,
    output logic             addr_oe,
    output logic             init_done,
    output logic             ref_overdue
);
    strobe_t          strb;
    logic             pend_any;
    logic             pend_multi;
    logic             served;
    logic             row_adv;
    logic [ROW_W-1:0] row;

    rfsh_interval #(
        .REFI_CYC (REFI_CYC),
        .MAX_PEND (MAX_PEND)
    ) u_interval (
        .clk        (clk),
        .rst        (rst),
        .run        (init_done),
        .served     (served),
        .pend_any   (pend_any),
        .pend_multi (pend_multi),
        .overdue    (ref_overdue)
    );

    rfsh_row_ctr #(
        .ROW_W (ROW_W)
    ) u_row (
        .clk (clk),
        .rst (rst),
        .adv (row_adv),
        .row (row)
    );

    rfsh_seq_fsm #(
        .PAUSE_CYC   (PAUSE_CYC),
        .INIT_CYCLES (INIT_CYCLES),
        .T_CSR       (T_CSR),
        .T_RAS       (T_RAS),
        .T_RP        (T_RP)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_ronly (ras_only_mode),
        .gnt        (ref_gnt),
        .pend_any   (pend_any),
        .pend_multi (pend_multi),
        .strb       (strb),
        .own        (strobe_own),
        .init_done  (init_done),
        .served     (served),
        .row_adv    (row_adv)
    );

    assign ras_n   = strb.ras_n;
    assign cas_n   = strb.cas_n;
    assign we_n    = strb.we_n;
    assign addr_oe = strb.addr_oe;
    assign addr    = strb.addr_oe ? row : '0;
    assign ref_req = init_done && (pend_any || strobe_own);

endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
    parameter int unsigned PAUSE_CYC = 10100,
    parameter int unsigned T_RAS     = 7
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic addr_oe,
    input logic init_done,
    input logic ref_overdue,
    input logic ref_req,
    input logic strobe_own
);
    localparam int unsigned SW = $clog2(PAUSE_CYC + 1);
    localparam int unsigned LW = $clog2(T_RAS + 2);

    logic [SW-1:0] since_rst;
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                            since_rst <= '0;
        else if (since_rst != SW'(PAUSE_CYC)) since_rst <= since_rst + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || ras_n)                 low_run <= '0;
        else if (low_run != LW'(T_RAS + 1)) low_run <= low_run + 1'b1;
    end

    // R2
    pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst < SW'(PAUSE_CYC)) |-> (ras_n && cas_n));

    // R12
    ras_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_run == LW'(T_RAS)));

    // R4
    cbr_cas_first_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    // R4
    cbr_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !addr_oe);

    // R6
    ronly_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && cas_n) |-> addr_oe);

    // R3
    init_hold_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R11
    overdue_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ref_overdue |=> ref_overdue);

    // R9
    own_req_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_own && init_done) |-> ref_req);

endmodule

bind dram_refresh_seq rfsh_seq_chk #(
    .PAUSE_CYC (PAUSE_CYC),
    .T_RAS     (T_RAS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .addr_oe     (addr_oe),
    .init_done   (init_done),
    .ref_overdue (ref_overdue),
    .ref_req     (ref_req),
    .strobe_own  (strobe_own)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
    localparam int ROW_W    = 10;
    localparam int PAUSE    = 30;
    localparam int NINIT    = 8;
    localparam int REFI     = 40;
    localparam int MAXP     = 3;
    localparam int TCSR     = 1;
    localparam int TRAS     = 3;
    localparam int TRP      = 2;
    localparam int NLONG    = 1030;

    typedef struct packed {
        logic             ronly;
        logic             chained;
        logic [ROW_W-1:0] row;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_only_mode = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, strobe_own, ras_n, cas_n, we_n, addr_oe, init_done, ref_overdue;
    logic [ROW_W-1:0] addr;

    always #10 clk = ~clk;

    dram_refresh_seq #(
        .ROW_W (ROW_W), .PAUSE_CYC (PAUSE), .INIT_CYCLES (NINIT), .REFI_CYC (REFI),
        .MAX_PEND (MAXP), .T_CSR (TCSR), .T_RAS (TRAS), .T_RP (TRP)
    ) u0 (
        .clk (clk), .rst (rst), .ras_only_mode (ras_only_mode), .ref_gnt (ref_gnt),
        .ref_req (ref_req), .strobe_own (strobe_own), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .addr (addr), .addr_oe (addr_oe), .init_done (init_done),
        .ref_overdue (ref_overdue)
    );

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // monitor / scoreboard
    bit prev_ras = 1'b1;
    int low_run = 0, high_run = 0, cas_low_run = 0, ncyc = 0, last_fall = 0;
    bit cas_high_seen = 1'b0, had_pulse = 1'b0, last_fall_ok = 1'b0;
    bit spacing_on = 1'b0, req_early = 1'b0;

    always @(negedge clk) begin
        exp_t e;
        ncyc++;
        if (rst) begin
            prev_ras = 1'b1; low_run = 0; high_run = 0; cas_low_run = 0;
            cas_high_seen = 1'b0; had_pulse = 1'b0; last_fall_ok = 1'b0;
        end else begin
            if (ref_req && !init_done) req_early = 1'b1;
            if (prev_ras && !ras_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 refresh without grant", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(cas_n == e.ronly, "R6 cycle style on cas_n", int'(cas_n), int'(e.ronly));
                    chk(we_n == 1'b1, "R4 we_n high", int'(we_n), 1);
                    chk(high_run >= TRP, "R5 precharge width", high_run, TRP);
                    if (!e.ronly) begin
                        chk(cas_low_run >= TCSR, "R4 cas lead", cas_low_run, TCSR);
                        chk(addr_oe == 1'b0, "R4 address undriven", int'(addr_oe), 0);
                        chk((had_pulse && !cas_high_seen) == e.chained, "R5 cas held low",
                            int'(had_pulse && !cas_high_seen), int'(e.chained));
                    end else begin
                        chk(addr_oe == 1'b1, "R6 address driven", int'(addr_oe), 1);
                        chk(addr == e.row, "R7 row address", int'(addr), int'(e.row));
                    end
                    if (spacing_on) begin
                        if (last_fall_ok)
                            chk(ncyc - last_fall == REFI, "R8 refresh spacing", ncyc - last_fall, REFI);
                        last_fall = ncyc;
                        last_fall_ok = 1'b1;
                    end else begin
                        last_fall_ok = 1'b0;
                    end
                end
                had_pulse = 1'b1;
            end
            if (!prev_ras && ras_n) begin
                chk(low_run == TRAS, "R12 ras pulse width", low_run, TRAS);
                cas_high_seen = 1'b0;
            end
            if (ras_n) begin high_run++; low_run = 0; end
            else       begin low_run++; high_run = 0; end
            if (cas_n) begin cas_high_seen = 1'b1; cas_low_run = 0; end
            else       cas_low_run++;
            prev_ras = ras_n;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    task automatic apply_reset(input logic mode);
        rst = 1'b1;
        ras_only_mode = mode;
        ref_gnt = 1'b0;
        repeat (4) @(negedge clk);
        chk({ras_n, cas_n, we_n, addr_oe, init_done, ref_req, ref_overdue, strobe_own} == 8'b1110_0000,
            "R1 reset outputs",
            int'({ras_n, cas_n, we_n, addr_oe, init_done, ref_req, ref_overdue, strobe_own}), 8'hE0);
        chk(addr == '0, "R1 reset address", int'(addr), 0);
        req_early = 1'b0;
        rst = 1'b0;
    endtask

    task automatic run_init(input string tag);
        bit quiet = 1'b1;
        int n = 0;
        for (int i = 0; i < PAUSE; i++) begin
            @(negedge clk);
            if (!(ras_n && cas_n)) quiet = 1'b0;
        end
        chk(quiet, "R2 pause keeps strobes idle", int'(quiet), 1);
        while (!init_done && n < 400) begin @(negedge clk); n++; end
        chk(init_done == 1'b1, tag, int'(init_done), 1);
        chk(exp_q.size() == 0, "R3 all init cycles ran", exp_q.size(), 0);
        chk(req_early == 1'b0, "R3 ref_req low during init", int'(req_early), 0);
    endtask

    initial begin
        int n;
        int t0;
        // RAS-only initialization: rows 0..7
        for (int i = 0; i < NINIT; i++) exp_q.push_back('{ronly: 1'b1, chained: 1'b0, row: ROW_W'(i)});
        apply_reset(1'b1);
        run_init("R3 init_done after RAS-only init");

        // CAS-before-RAS initialization: chained after the first
        exp_q.delete();
        for (int i = 0; i < NINIT; i++) exp_q.push_back('{ronly: 1'b0, chained: (i != 0), row: '0});
        apply_reset(1'b0);
        run_init("R3 init_done after CBR init");

        // denial: pending saturates, overdue set
        n = 0;
        while (!ref_req && n < 200) begin @(negedge clk); n++; end
        chk(ref_req == 1'b1, "R8 first request after init", int'(ref_req), 1);
        t0 = ncyc;
        repeat (20) @(negedge clk);
        chk(ref_overdue == 1'b0, "R11 no overdue yet", int'(ref_overdue), 0);
        chk(ref_req == 1'b1, "R9 request held while pending", int'(ref_req), 1);
        while (ncyc < t0 + 170) @(negedge clk);
        chk(ref_overdue == 1'b1, "R11 overdue after missed interval", int'(ref_overdue), 1);
        for (int i = 0; i < MAXP; i++) exp_q.push_back('{ronly: 1'b0, chained: (i != 0), row: '0});
        ref_gnt = 1'b1;
        n = 0;
        while ((exp_q.size() != 0 || strobe_own) && n < 100) begin @(negedge clk); n++; end
        ref_gnt = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10 saturated burst ran", exp_q.size(), 0);
        chk(ref_req == 1'b0, "R10 nothing left after MAX_PEND", int'(ref_req), 0);
        chk(ref_overdue == 1'b1, "R11 overdue sticky", int'(ref_overdue), 1);

        // RAS-only steady state with wrap
        ras_only_mode = 1'b1;
        ref_gnt = 1'b1;
        spacing_on = 1'b1;
        for (int i = 0; i < NLONG; i++) exp_q.push_back('{ronly: 1'b1, chained: 1'b0, row: ROW_W'(i % 1024)});
        n = 0;
        while ((exp_q.size() != 0 || strobe_own) && n < NLONG * REFI + 400) begin @(negedge clk); n++; end
        spacing_on = 1'b0;
        chk(exp_q.size() == 0, "R7 all rows refreshed incl. wrap", exp_q.size(), 0);
        chk(ref_overdue == 1'b1, "R11 overdue still set", int'(ref_overdue), 1);
        report();
    end

endmodule